// File: doc/BRIEF.md
# Paging Codeword Corrector and Status Serialiser

This block receives one 32-bit paging codeword, the word that follows a matched address. It decodes the word as a BCH(31,21) code with an added overall parity bit. The decoder repairs one flipped bit, or two flipped bits that sit next to each other. Any other error that leaves a nonzero syndrome is reported as uncorrectable. In that case the word is passed on unchanged.

After decoding, the block reads the flag bit of the word. A flag of 1 marks a message. The block then shifts a 23-bit status word to the host, one bit per strobe pulse. A flag of 0 marks an address or idle word. The block then sends nothing and raises a one-cycle terminator pulse, which tells the receive controller to stop collecting message words. Demodulation, bit timing and sync search happen upstream of this block.

Top module: `bch_msg_corrector`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `ser_strobe`, `ser_data` and `term_pulse` are all 0.
- R2: Codeword layout: `cw_in[31]` is the flag bit, `cw_in[30:11]` are the 20 data bits, `cw_in[10:1]` are the check bits for generator x^10+x^9+x^8+x^6+x^5+x^3+1, and `cw_in[0]` makes the whole word even. For an error-free message, the serial word carries the data bits unchanged with error code {E0,E1} = 00.
- R3: A single flipped bit in `cw_in[31:1]` is corrected. The error code is {E0,E1} = 10.
- R4: Two flipped bits in neighbouring positions of `cw_in[31:1]` are corrected. The error code is {E0,E1} = 01.
- R5: Two flipped bits that are not neighbours give error code {E0,E1} = 11. The word is then sent without any correction.
- R6: The last serial bit, PE, is the XOR of all 32 received bits before correction (1 means the parity check failed). A flip of `cw_in[0]` alone gives error code 00 and PE = 1.
- R7: If the flag bit after correction is 0, no strobe is produced. Instead `term_pulse` is high for exactly one cycle, two cycles after the accept edge, and `busy` falls.
- R8: A message produces exactly 23 strobes. The bits go out in this order: `cw_in[30]` first through `cw_in[11]`, then E0, then E1, then PE.
- R9: Each serial bit is placed on `ser_data` SETUP_CYC clocks before its strobe rises. `ser_strobe` then stays high for HOLD_CYC clocks, and `ser_data` does not change during that whole window.
- R10: `busy` goes high in the cycle after an accepted word. It stays high for 1 + 23*(SETUP_CYC+HOLD_CYC) cycles for a message. An `accept` seen while `busy` is high is ignored.
- R11: The message/terminator decision uses the corrected flag. It falls back to the received flag only when the word is uncorrectable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| accept | input | 1 | Capture `cw_in` when the block is idle |
| cw_in | input | 32 | Received codeword, flag bit at the MSB |
| busy | output | 1 | Word held, being decoded or being serialised |
| ser_data | output | 1 | Serial status bit to the host |
| ser_strobe | output | 1 | Host sampling strobe; rising edge marks a valid bit |
| term_pulse | output | 1 | One-cycle pulse: word was an address or idle word |

## Verification
The bench builds its own valid codewords with a shift-register encoder. It then injects error masks chosen to separate the decoder's outcomes.
- Clean words, including all-zero and all-one data, confirm the data path and the bit order.
- Single flips in the data, check and flag regions each select a different correction tap.
- Neighbouring pairs at both ends of the 31-bit span exercise the edges of the pair search.
- A spread pair must give code 11 and the raw data.
- Flips of the parity bit, alone and together with another flip, separate PE from the error code.
- Address words with a flipped flag separate a corrected terminator from an uncorrectable word that falls back to the message path.

// File: rtl/bchdec_pkg.sv
package bchdec_pkg;

  localparam int CW_BITS    = 32;
  localparam int BCH_N      = 31;
  localparam int CHK_BITS   = 10;
  localparam int DATA_BITS  = 20;
  localparam int STAT_BITS  = DATA_BITS + 3;
  // generator x^10+x^9+x^8+x^6+x^5+x^3+1 without its leading term
  localparam logic [CHK_BITS-1:0] GEN_LOW = 10'h369;

  // {E0,E1}
  typedef enum logic [1:0] {
    EC_NONE = 2'b00,
    EC_PAIR = 2'b01,
    EC_ONE  = 2'b10,
    EC_BAD  = 2'b11
  } ecode_e;

  // remainder of a 31-bit word (MSB = highest degree) divided by the generator
  function automatic logic [CHK_BITS-1:0] poly_rem(input logic [BCH_N-1:0] c);
    logic [CHK_BITS-1:0] s;
    logic fb;
    s = '0;
    for (int i = BCH_N - 1; i >= 0; i--) begin
      fb = s[CHK_BITS-1];
      s  = {s[CHK_BITS-2:0], c[i]};
      if (fb) s = s ^ GEN_LOW;
    end
    return s;
  endfunction

  // x^p mod generator
  function automatic logic [CHK_BITS-1:0] xpow_rem(input int p);
    logic [CHK_BITS-1:0] r;
    logic fb;
    r = 1;
    for (int i = 0; i < BCH_N; i++) begin
      if (i < p) begin
        fb = r[CHK_BITS-1];
        r  = {r[CHK_BITS-2:0], 1'b0};
        if (fb) r = r ^ GEN_LOW;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/bch_syndrome.sv
module bch_syndrome
  import bchdec_pkg::*;
(
  input  logic [CW_BITS-1:0]  cw,
  output logic [CHK_BITS-1:0] syn,
  output logic                par_fail
);
  // cw[31:1] is the 31-bit BCH word, cw[0] the overall parity bit
  assign syn      = poly_rem(cw[CW_BITS-1:1]);
  assign par_fail = ^cw;
endmodule

// File: rtl/bch_locator.sv
module bch_locator
  import bchdec_pkg::*;
(
  input  logic [CHK_BITS-1:0] syn,
  output logic [BCH_N-1:0]    flip_mask,
  output ecode_e              ecode
);
  logic [BCH_N-1:0] one_hit;
  logic [BCH_N-2:0] pair_hit;
  logic [BCH_N-1:0] pair_mask;

  genvar p;
  generate
    for (p = 0; p < BCH_N; p++) begin : g_one
      localparam logic [CHK_BITS-1:0] SYN_ONE = xpow_rem(p);
      assign one_hit[p] = (syn == SYN_ONE);
    end
    for (p = 0; p < BCH_N - 1; p++) begin : g_pair
      localparam logic [CHK_BITS-1:0] SYN_PAIR = xpow_rem(p) ^ xpow_rem(p + 1);
      assign pair_hit[p] = (syn == SYN_PAIR);
    end
  endgenerate

  always_comb begin
    pair_mask = '0;
    for (int i = 0; i < BCH_N - 1; i++) begin
      if (pair_hit[i]) pair_mask = pair_mask | (BCH_N'(3) << i);
    end
  end

  always_comb begin
    if (syn == '0) begin
      ecode     = EC_NONE;
      flip_mask = '0;
    end else if (|one_hit) begin
      ecode     = EC_ONE;
      flip_mask = one_hit;
    end else if (|pair_hit) begin
      ecode     = EC_PAIR;
      flip_mask = pair_mask;
    end else begin
      ecode     = EC_BAD;
      flip_mask = '0;
    end
  end
endmodule

// File: rtl/status_serializer.sv
module status_serializer #(
  parameter int WORD_W    = 23,
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic              sdata,
  output logic              sstrobe,
  output logic              active
);
  localparam int PERIOD = SETUP_CYC + HOLD_CYC;
  localparam int CYC_W  = $clog2(PERIOD + 1);
  localparam int BIT_W  = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] shreg;
  logic [CYC_W-1:0]  cyc;
  logic [BIT_W-1:0]  bit_idx;
  logic              bit_end;
  logic              last_bit;

  assign bit_end  = (cyc == CYC_W'(PERIOD - 1));
  assign last_bit = (bit_idx == BIT_W'(WORD_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      shreg   <= '0;
      cyc     <= '0;
      bit_idx <= '0;
    end else if (load) begin
      active  <= 1'b1;
      shreg   <= word;
      cyc     <= '0;
      bit_idx <= '0;
    end else if (active) begin
      if (bit_end) begin
        cyc <= '0;
        if (last_bit) begin
          active <= 1'b0;
          shreg  <= '0;
        end else begin
          bit_idx <= bit_idx + 1'b1;
          shreg   <= {shreg[WORD_W-2:0], 1'b0};
        end
      end else begin
        cyc <= cyc + 1'b1;
      end
    end
  end

  assign sdata   = active & shreg[WORD_W-1];
  assign sstrobe = active & (cyc >= CYC_W'(SETUP_CYC));

  // R9: data settled before each strobe rise
  assert_setup_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sstrobe) |-> $stable(sdata));
  // R9: data held while the strobe is high
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sstrobe && $past(sstrobe)) |-> $stable(sdata));
  // R8: bit index never passes the word length
  assert_bit_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (bit_idx < BIT_W'(WORD_W)));
  // R10: a new load only arrives when idle
  assert_load_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !active);
endmodule

// File: rtl/bch_msg_corrector.sv
module bch_msg_corrector
  import bchdec_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic [CW_BITS-1:0] cw_in,
  output logic               busy,
  output logic               ser_data,
  output logic               ser_strobe,
  output logic               term_pulse
);
  logic [CW_BITS-1:0]   cw_q;
  logic                 held;
  logic                 take;
  logic [CHK_BITS-1:0]  syn;
  logic                 par_fail;
  logic [BCH_N-1:0]     flip_mask;
  ecode_e               ecode;
  logic [BCH_N-1:0]     fixed;
  logic                 is_msg;
  logic [STAT_BITS-1:0] status;
  logic                 ser_load;
  logic                 ser_active;

  assign take = accept & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cw_q <= '0;
      held <= 1'b0;
    end else begin
      if (take) cw_q <= cw_in;
      held <= take;
    end
  end

  bch_syndrome u_syn (
    .cw       (cw_q),
    .syn      (syn),
    .par_fail (par_fail)
  );

  bch_locator u_loc (
    .syn       (syn),
    .flip_mask (flip_mask),
    .ecode     (ecode)
  );

  assign fixed    = cw_q[CW_BITS-1:1] ^ flip_mask;
  assign is_msg   = fixed[BCH_N-1];
  assign status   = {fixed[BCH_N-2:CHK_BITS], ecode, par_fail};
  assign ser_load = held & is_msg;

  always_ff @(posedge clk) begin
    if (!rst_n) term_pulse <= 1'b0;
    else        term_pulse <= held & ~is_msg;
  end

  status_serializer #(
    .WORD_W    (STAT_BITS),
    .SETUP_CYC (SETUP_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ser_load),
    .word    (status),
    .sdata   (ser_data),
    .sstrobe (ser_strobe),
    .active  (ser_active)
  );

  assign busy = held | ser_active;

  // R10: an accepted word raises busy in the next cycle
  assert_busy_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !busy) |=> busy);
  // R10: accept while busy leaves the held word untouched
  assert_ignore_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && busy) |=> $stable(cw_q));
  // R4: the locator never flips more than a pair
  assert_flip_weight_R4: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> ($countones(flip_mask) <= 2));
  // R5: uncorrectable words pass through unchanged
  assert_bad_noflip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (held && ecode == EC_BAD) |-> (flip_mask == '0));
  // R7: a terminator never coincides with serial output
  assert_term_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    term_pulse |-> (!ser_active && !busy));
endmodule

// File: tb/sim_bch_msg_corrector.sv
module sim_bch_msg_corrector;
  localparam int S = 2;
  localparam int H = 3;
  localparam int P = S + H;
  localparam int NV = 14;
  localparam logic [9:0] G = 10'h369;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        accept = 1'b0;
  logic [31:0] cw_in = '0;
  logic        busy, ser_data, ser_strobe, term_pulse;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bch_msg_corrector #(.SETUP_CYC(S), .HOLD_CYC(H)) u0 (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cw_in(cw_in),
    .busy(busy), .ser_data(ser_data), .ser_strobe(ser_strobe),
    .term_pulse(term_pulse)
  );

  // fields: [54] flag, [53:34] data, [33:2] error mask, [1:0] expected {E0,E1}
  localparam logic [54:0] VEC [NV] = '{
    {1'b1, 20'hA5C3F, 32'h0000_0000, 2'b00},  // R2 clean
    {1'b1, 20'h00000, 32'h0000_0000, 2'b00},  // R2 zero data
    {1'b1, 20'h12345, 32'h0010_0000, 2'b10},  // R3 data flip
    {1'b1, 20'hFFFFF, 32'h0000_0020, 2'b10},  // R3 check flip
    {1'b1, 20'h0F0F0, 32'h8000_0000, 2'b10},  // R3 R11 flag flip on message
    {1'b1, 20'h3C3C3, 32'h0000_C000, 2'b01},  // R4 middle pair
    {1'b1, 20'h5A5A5, 32'hC000_0000, 2'b01},  // R4 top pair incl flag
    {1'b1, 20'h9E371, 32'h0000_0006, 2'b01},  // R4 bottom pair
    {1'b1, 20'h6B1D4, 32'h0200_0200, 2'b11},  // R5 spread pair
    {1'b1, 20'hC0FFE, 32'h0000_0001, 2'b00},  // R6 parity bit only
    {1'b1, 20'h24680, 32'h0000_1001, 2'b10},  // R6 flip plus parity flip
    {1'b0, 20'h13579, 32'h0000_0000, 2'b00},  // R7 address word
    {1'b0, 20'h2468A, 32'h8000_0000, 2'b10},  // R11 flag flip corrected to address
    {1'b0, 20'h0BEEF, 32'h8000_0010, 2'b11}   // R11 uncorrectable, raw flag decides
  };

  function automatic logic [31:0] encode(input logic flag, input logic [19:0] data);
    logic [20:0] m;
    logic [9:0] r;
    logic fb;
    logic [30:0] c;
    m = {flag, data};
    r = '0;
    for (int i = 20; i >= 0; i--) begin
      fb = m[i] ^ r[9];
      r = {r[8:0], 1'b0} ^ (fb ? G : 10'h000);
    end
    c = {m, r};
    return {c, ^c};
  endfunction

  task automatic chk(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_word(input logic [31:0] w, input int poke_at, input logic [31:0] pw,
                          output logic [22:0] got, output int nstb, output bit term,
                          output int nbusy, output bit tim_ok);
    logic ps, pd;
    int hi, lo;
    got = '0; nstb = 0; term = 0; nbusy = 0; tim_ok = 1;
    ps = 0; pd = 0; hi = 0; lo = 0;
    @(negedge clk); accept = 1'b1; cw_in = w;
    @(negedge clk); accept = 1'b0; cw_in = '0;
    for (int k = 0; k < 5000; k++) begin
      if (term_pulse) term = 1;
      if (!busy) break;
      nbusy++;
      if (ser_strobe && !ps) begin
        if (ser_data !== pd) tim_ok = 0;
        if (nstb > 0 && lo != S) tim_ok = 0;
        got = {got[21:0], ser_data};
        nstb++;
        hi = 1;
      end else if (ser_strobe) begin
        hi++;
        if (ser_data !== pd) tim_ok = 0;
      end else if (ps) begin
        if (hi != H) tim_ok = 0;
        lo = 1;
      end else begin
        lo++;
      end
      ps = ser_strobe; pd = ser_data;
      @(negedge clk);
      if (k + 1 == poke_at) begin accept = 1'b1; cw_in = pw; end
      else begin accept = 1'b0; cw_in = '0; end
    end
    accept = 1'b0;
    if (ps && hi != H) tim_ok = 0;
  endtask

  function automatic string tag_of(input logic [1:0] code);
    case (code)
      2'b00: return "R2";
      2'b10: return "R3";
      2'b01: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [22:0] got;
    int nstb, nbusy;
    bit term, tim_ok;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1", {busy, ser_strobe, ser_data, term_pulse} == 4'b0, {28'b0, busy, ser_strobe, ser_data, term_pulse}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {busy, ser_strobe, ser_data, term_pulse} == 4'b0, {28'b0, busy, ser_strobe, ser_data, term_pulse}, 0);

    for (int v = 0; v < NV; v++) begin
      logic flag;
      logic [19:0] data;
      logic [31:0] mask, rx;
      logic [1:0] code;
      logic [19:0] ebits;
      logic [22:0] eword;
      bit eterm;
      flag = VEC[v][54];
      data = VEC[v][53:34];
      mask = VEC[v][33:2];
      code = VEC[v][1:0];
      rx = encode(flag, data) ^ mask;
      ebits = (code == 2'b11) ? rx[30:11] : data;
      eword = {ebits, code, ^rx};
      eterm = (code == 2'b11) ? !rx[31] : !flag;
      run_word(rx, -1, '0, got, nstb, term, nbusy, tim_ok);
      if (mask[31]) chk("R11", term == eterm, {31'b0, term}, {31'b0, eterm});
      if (eterm) begin
        chk("R7", term == 1'b1, {31'b0, term}, 1);
        chk("R7", nstb == 0, nstb, 0);
      end else begin
        chk(tag_of(code), got == eword, {9'b0, got}, {9'b0, eword});
        chk("R6", got[0] == ^rx, {31'b0, got[0]}, {31'b0, ^rx});
        chk("R8", nstb == 23, nstb, 23);
        chk("R9", tim_ok, {31'b0, tim_ok}, 1);
        chk("R10", nbusy == 1 + 23 * P, nbusy, 1 + 23 * P);
        chk("R7", term == 1'b0, {31'b0, term}, 0);
      end
    end

    // R10: accept while busy is ignored (an address word poked mid-run)
    begin
      logic [31:0] a;
      logic [22:0] eword;
      a = encode(1'b1, 20'h7E1A3);
      eword = {20'h7E1A3, 2'b00, 1'b0};
      run_word(a, 12, encode(1'b0, 20'h00001), got, nstb, term, nbusy, tim_ok);
      chk("R10", got == eword, {9'b0, got}, {9'b0, eword});
      chk("R10", term == 1'b0 && nbusy == 1 + 23 * P, nbusy, 1 + 23 * P);
      repeat (4) begin
        @(negedge clk);
        chk("R10", !busy && !term_pulse, {30'b0, busy, term_pulse}, 0);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule